// File: doc/BRIEF.md
# Condition Code and Interrupt-Level Register

This block is the status register of a small 8-bit processor core. Each cycle it can take the result of an ALU or shifter operation and update five arithmetic flags: carry, overflow, zero, negative and half-carry. Each flag updates only when its own enable is high. The ALU supplies the 8-bit result, the sign bits of both operands, the carry out of bit 7, the carry out of bit 3 and, for shifts, the bit that was shifted out. A 2-bit operation class tells the block whether the operation was an add, a subtract, a logic operation or a shift.

The same register holds a global interrupt enable and a 2-bit current interrupt level. Software can load the whole register through a direct write port, and that write overrides any flag update in the same cycle. When an interrupt request arrives with a 2-bit level, the block asserts an accept signal in the same cycle if two things hold: interrupts are enabled, and the request is more urgent than the level currently in service. A smaller number means a more urgent request. Level 3 means no interrupt is in service.

Top module: `ccr_unit`

## Requirements
- R1: After reset the register reads 8'hC0: level field = 3, interrupt enable = 0, and all arithmetic flags = 0.
- R2: Register layout: bits 7:6 level, bit 5 interrupt enable, bit 4 H, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. When N is updated, it takes bit 7 of the result.
- R3: When Z is updated, it becomes 1 if the result is zero and 0 otherwise.
- R4: When V is updated, it is set on two's-complement overflow. Operation class codes are add=0, subtract=1, logic=2, shift=3. For add, V is set when both operand signs are equal and the result sign differs from them. For subtract, V is set when the operand signs differ and the result sign differs from the first operand's sign. For logic and shift, V is cleared.
- R5: When C is updated, it takes the shift-out bit for the shift class and the carry out of bit 7 for every other class.
- R6: When H is updated, it takes the carry out of bit 3.
- R7: A flag whose enable is low keeps its value. Flag updates never change the interrupt enable bit or the level field.
- R8: A direct write loads all eight bits from the write data in the next cycle, and it takes priority over any flag update in that cycle.
- R9: Interrupt accept is high only when the request strobe is high, the interrupt enable is 1, and the request level is numerically below the level field.
- R10: Interrupt accept is combinational from the current register contents and the request inputs, so it can be seen in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_i | input | 8 | Operation result |
| sign_a_i | input | 1 | Sign bit of the first operand |
| sign_b_i | input | 1 | Sign bit of the second operand |
| cy7_i | input | 1 | Carry or borrow out of bit 7 |
| cy3_i | input | 1 | Carry or borrow out of bit 3 |
| shout_i | input | 1 | Bit shifted out by a shift operation |
| opc_i | input | 2 | Operation class (0 add, 1 sub, 2 logic, 3 shift) |
| upd_h_i | input | 1 | Update enable for H |
| upd_n_i | input | 1 | Update enable for N |
| upd_z_i | input | 1 | Update enable for Z |
| upd_v_i | input | 1 | Update enable for V |
| upd_c_i | input | 1 | Update enable for C |
| wr_en_i | input | 1 | Direct write strobe |
| wr_data_i | input | 8 | Direct write data |
| irq_req_i | input | 1 | Interrupt request strobe |
| irq_lvl_i | input | 2 | Request level (0 is the most urgent) |
| ccr_o | output | 8 | Register contents |
| irq_ack_o | output | 1 | Interrupt accept |

## Verification
The hardest situations to reach from the ports are these: a partial update, where only some flags are enabled and the rest must keep values left by earlier operations, and the accept comparison at its boundaries, where the request level equals the level field. The stimulus table runs its vectors back to back, so the state left by one vector is the starting point of the next. A run of partial-enable vectors therefore shows each retained flag at the ports. The directed tests load the level field and the enable bit through the write port and then sweep the request level across each boundary. One write is issued together with a full flag update, which shows that the write takes priority.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_SHIFT = 2'd3
  } opc_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } aflags_t;

  localparam int NUM_AFLAGS = 5;

  // Two's-complement overflow from the operand signs and the result sign.
  function automatic logic ovf_of(opc_e op, logic sa, logic sb, logic sr);
    logic o;
    case (op)
      OPC_ADD: o = (sa == sb) && (sr != sa);
      OPC_SUB: o = (sa != sb) && (sr != sa);
      default: o = 1'b0;
    endcase
    return o;
  endfunction

  // Carry source: the shift-out bit for shifts, the bit-7 carry otherwise.
  function automatic logic carry_of(opc_e op, logic c7, logic so);
    return (op == OPC_SHIFT) ? so : c7;
  endfunction

  // Accept when enabled and the request is strictly more urgent.
  function automatic logic accept_of(logic req, logic ien, logic [1:0] lvl,
                                     logic [1:0] cur);
    return req && ien && (lvl < cur);
  endfunction

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic             cy7_i,
  input  logic             cy3_i,
  input  logic             shout_i,
  input  logic [1:0]       opc_i,
  output aflags_t          nxt_o
);
  opc_e op;
  logic res_msb;

  always_comb begin
    op      = opc_e'(opc_i);
    res_msb = res_i[RES_W-1];
    nxt_o.h = cy3_i;
    nxt_o.n = res_msb;
    nxt_o.z = (res_i == '0);
    nxt_o.v = ovf_of(op, sign_a_i, sign_b_i, res_msb);
    nxt_o.c = carry_of(op, cy7_i, shout_i);
  end
endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate
  import ccr_pkg::*;
(
  input  logic       req_i,
  input  logic       ien_i,
  input  logic [1:0] lvl_i,
  input  logic [1:0] cur_lvl_i,
  output logic       ack_o
);
  always_comb ack_o = accept_of(req_i, ien_i, lvl_i, cur_lvl_i);
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int LVL_W = 2,
  parameter logic [LVL_W-1:0] IL_RESET = '1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [RES_W-1:0]                res_i,
  input  logic                            sign_a_i,
  input  logic                            sign_b_i,
  input  logic                            cy7_i,
  input  logic                            cy3_i,
  input  logic                            shout_i,
  input  logic [1:0]                      opc_i,
  input  logic                            upd_h_i,
  input  logic                            upd_n_i,
  input  logic                            upd_z_i,
  input  logic                            upd_v_i,
  input  logic                            upd_c_i,
  input  logic                            wr_en_i,
  input  logic [LVL_W+NUM_AFLAGS:0]       wr_data_i,
  input  logic                            irq_req_i,
  input  logic [LVL_W-1:0]                irq_lvl_i,
  output logic [LVL_W+NUM_AFLAGS:0]       ccr_o,
  output logic                            irq_ack_o
);
  localparam int CCR_W  = LVL_W + NUM_AFLAGS + 1;
  localparam int IEN_B  = NUM_AFLAGS;
  localparam int LVL_LO = NUM_AFLAGS + 1;

  aflags_t                nxt_flags;
  logic [NUM_AFLAGS-1:0]  flags_q;
  logic [NUM_AFLAGS-1:0]  upd_vec;
  logic [NUM_AFLAGS-1:0]  flag_load;
  logic                   ien_q;
  logic [LVL_W-1:0]       lvl_q;
  logic                   wr_take;

  assign upd_vec = {upd_h_i, upd_n_i, upd_z_i, upd_v_i, upd_c_i};
  assign wr_take = wr_en_i;

  ccr_flag_calc #(.RES_W(RES_W)) calc_i (
    .res_i   (res_i),
    .sign_a_i(sign_a_i),
    .sign_b_i(sign_b_i),
    .cy7_i   (cy7_i),
    .cy3_i   (cy3_i),
    .shout_i (shout_i),
    .opc_i   (opc_i),
    .nxt_o   (nxt_flags)
  );

  for (genvar g = 0; g < NUM_AFLAGS; g++) begin : g_flag
    assign flag_load[g] = upd_vec[g] && !wr_take;
    always_ff @(posedge clk) begin
      if (!rst_n)          flags_q[g] <= 1'b0;
      else if (wr_take)    flags_q[g] <= wr_data_i[g];
      else if (flag_load[g]) flags_q[g] <= nxt_flags[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      lvl_q <= IL_RESET;
    end else if (wr_take) begin
      ien_q <= wr_data_i[IEN_B];
      lvl_q <= wr_data_i[CCR_W-1:LVL_LO];
    end
  end

  assign ccr_o = {lvl_q, ien_q, flags_q};

  ccr_irq_gate gate_i (
    .req_i    (irq_req_i),
    .ien_i    (ien_q),
    .lvl_i    (irq_lvl_i),
    .cur_lvl_i(lvl_q),
    .ack_o    (irq_ack_o)
  );
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] res_i,
  input logic       cy3_i,
  input logic       shout_i,
  input logic [1:0] opc_i,
  input logic       upd_h_i,
  input logic       upd_n_i,
  input logic       upd_z_i,
  input logic       upd_v_i,
  input logic       upd_c_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       irq_req_i,
  input logic [1:0] irq_lvl_i,
  input logic [7:0] ccr_o,
  input logic       irq_ack_o
);
  a_r2_neg_follows_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_n_i && !wr_en_i) |=> ccr_o[3] == $past(res_i[7]));

  a_r3_zero_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_z_i && !wr_en_i) |=> ccr_o[2] == ($past(res_i) == 8'h00));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_v_i && !wr_en_i && opc_i[1]) |=> !ccr_o[1]);

  a_r5_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_c_i && !wr_en_i && opc_i == 2'd3) |=> ccr_o[0] == $past(shout_i));

  a_r6_half_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_h_i && !wr_en_i) |=> ccr_o[4] == $past(cy3_i));

  a_r7_hold_n: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_n_i && !wr_en_i) |=> $stable(ccr_o[3]));

  a_r7_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ccr_o[7:5]));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ccr_o == $past(wr_data_i));

  a_r9_accept_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (irq_req_i && ccr_o[5] && (irq_lvl_i < ccr_o[7:6])));

  a_r10_accept_when_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_i && ccr_o[5] && (irq_lvl_i < ccr_o[7:6])) |-> irq_ack_o);
endmodule

bind ccr_unit ccr_unit_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_i    (res_i),
  .cy3_i    (cy3_i),
  .shout_i  (shout_i),
  .opc_i    (opc_i),
  .upd_h_i  (upd_h_i),
  .upd_n_i  (upd_n_i),
  .upd_z_i  (upd_z_i),
  .upd_v_i  (upd_v_i),
  .upd_c_i  (upd_c_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .irq_req_i(irq_req_i),
  .irq_lvl_i(irq_lvl_i),
  .ccr_o    (ccr_o),
  .irq_ack_o(irq_ack_o)
);

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] res_i;
  logic       sign_a_i, sign_b_i, cy7_i, cy3_i, shout_i;
  logic [1:0] opc_i;
  logic       upd_h_i, upd_n_i, upd_z_i, upd_v_i, upd_c_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic       irq_req_i;
  logic [1:0] irq_lvl_i;
  logic [7:0] ccr_o;
  logic       irq_ack_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ccr_unit dut_i (.*);

  // Vector: opc[24:23] res[22:15] sa sb c7 c3 so [14:10] en{h,n,z,v,c}[9:5] exp{h,n,z,v,c}[4:0]
  localparam logic [24:0] VEC [12] = '{
    {2'd0, 8'h00, 5'b00110, 5'b11111, 5'b10101},
    {2'd0, 8'h80, 5'b00000, 5'b11111, 5'b01010},
    {2'd0, 8'h7F, 5'b11100, 5'b11111, 5'b00011},
    {2'd1, 8'h80, 5'b01110, 5'b11111, 5'b11011},
    {2'd1, 8'h7F, 5'b10000, 5'b11111, 5'b00010},
    {2'd1, 8'hFF, 5'b00110, 5'b11111, 5'b11001},
    {2'd2, 8'h00, 5'b11100, 5'b11111, 5'b00101},
    {2'd3, 8'h40, 5'b00011, 5'b11111, 5'b10001},
    {2'd3, 8'h80, 5'b00100, 5'b11111, 5'b01000},
    {2'd0, 8'h01, 5'b01110, 5'b00000, 5'b01000},
    {2'd0, 8'h00, 5'b00110, 5'b00100, 5'b01100},
    {2'd2, 8'h1C, 5'b00000, 5'b01000, 5'b00100}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {upd_h_i, upd_n_i, upd_z_i, upd_v_i, upd_c_i} = 5'b0;
    wr_en_i = 1'b0;
  endtask

  task automatic write_reg(logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    idle();
  endtask

  task automatic ack_probe(string tag, logic req, logic [1:0] lvl, logic exp);
    @(negedge clk);
    irq_req_i = req; irq_lvl_i = lvl;
    #1;
    check(tag, {7'd0, irq_ack_o}, {7'd0, exp});
    irq_req_i = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; res_i = '0; {sign_a_i, sign_b_i, cy7_i, cy3_i, shout_i} = '0;
    opc_i = '0; irq_req_i = 1'b0; irq_lvl_i = '0; wr_data_i = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset value", ccr_o, 8'hC0);
    ack_probe("R1 R9 accept blocked after reset", 1'b1, 2'd0, 1'b0);

    // R2..R7: table walk, state carries from vector to vector
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      opc_i = VEC[i][24:23];
      res_i = VEC[i][22:15];
      {sign_a_i, sign_b_i, cy7_i, cy3_i, shout_i} = VEC[i][14:10];
      {upd_h_i, upd_n_i, upd_z_i, upd_v_i, upd_c_i} = VEC[i][9:5];
      @(negedge clk);
      idle();
      check($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", i), ccr_o, {3'b110, VEC[i][4:0]});
    end

    // R8: write wins over a full update in the same cycle
    @(negedge clk);
    opc_i = 2'd0; res_i = 8'h00; {sign_a_i, sign_b_i, cy7_i, cy3_i, shout_i} = 5'b00110;
    {upd_h_i, upd_n_i, upd_z_i, upd_v_i, upd_c_i} = 5'b11111;
    wr_en_i = 1'b1; wr_data_i = 8'h2A;
    @(negedge clk);
    idle();
    check("R8 write priority", ccr_o, 8'h2A);

    // R9, R10: accept boundaries
    write_reg(8'hA0);
    ack_probe("R9 R10 lvl1 below IL2", 1'b1, 2'd1, 1'b1);
    ack_probe("R9 lvl2 equal IL2", 1'b1, 2'd2, 1'b0);
    ack_probe("R9 lvl3 above IL2", 1'b1, 2'd3, 1'b0);
    ack_probe("R9 no strobe", 1'b0, 2'd0, 1'b0);
    write_reg(8'h20);
    ack_probe("R9 IL0 blocks all", 1'b1, 2'd0, 1'b0);
    write_reg(8'hC0);
    ack_probe("R9 enable clear", 1'b1, 2'd0, 1'b0);
    write_reg(8'hE0);
    ack_probe("R9 R10 lvl2 below IL3", 1'b1, 2'd2, 1'b1);

    // R7: flag updates leave enable and level alone
    @(negedge clk);
    opc_i = 2'd1; res_i = 8'h80; {sign_a_i, sign_b_i, cy7_i, cy3_i, shout_i} = 5'b01110;
    {upd_h_i, upd_n_i, upd_z_i, upd_v_i, upd_c_i} = 5'b11111;
    @(negedge clk);
    idle();
    check("R7 control bits kept", ccr_o, 8'hFB);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule